// File: doc/BRIEF.md
# Two-Pin Edge Interrupt Register Block

This block watches two input pins and records a pending flag for each one when a chosen edge arrives. Each pin has three controls on a byte-wide read/write bus: an enable bit, a flag bit and a polarity bit, each held in its own register. Pin 0 occupies bit 5 and pin 1 occupies bit 6 of every register. All other bits are empty. A single registered interrupt request goes high while any enabled flag is pending.

Each pin is first resynchronised through two flops, and an edge is found by comparing two successive synchronised samples. The polarity bit selects rising or falling edges. A per-pin gating input marks a pin as lent to another function and suppresses edge detection on that pin. Software clears flags by writing ones. A flag is latched even while its enable bit is off, because the enable masks only the request output.

After reset, a small warm-up state machine keeps detection off until the sample pipeline holds real pin data. It steps through `ST_FILL_A` → `ST_FILL_B` → `ST_FILL_C` → `ST_LIVE`, advancing one state per clock. It stays in `ST_LIVE` until the next reset, and detection is allowed only in `ST_LIVE`.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the enable, flag and polarity registers read 0x00 and `irq` is 0.
- R2: Address 0 is enable, address 1 is flag, address 2 is polarity, and address 3 reads 0x00. Pin 0 maps to bit 5 and pin 1 to bit 6. All other bits read 0 and ignore writes. `bus_rdata` is 0x00 when `bus_sel` is low.
- R3: With polarity bit 0, a falling edge sets the flag. The flag becomes readable after the third rising clock edge that follows the pin change.
- R4: With polarity bit 1, a rising edge sets the flag, and a falling edge on that pin does not.
- R5: Changing a polarity bit while the pin is steady does not set a flag.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: A flag is set even when its enable bit is 0, and a flag whose enable bit is 0 does not raise `irq`.
- R8: `irq` equals the OR over both pins of (flag AND enable), delayed by one clock.
- R9: When an edge and a write-1-to-clear reach the same flag in the same cycle, the flag stays set.
- R10: While a pin's `pin_gate` bit is 1, edges on that pin do not set its flag.
- R11: During the three warm-up cycles after reset no flag is set, so pin levels present at reset never produce a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe when selected |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 2 | Asynchronous pin inputs |
| pin_gate | input | 2 | Per-pin detection block (1 = pin used elsewhere) |
| irq | output | 1 | Combined registered interrupt request |

## Verification
Directed sequences check each behaviour on its own:
- A single pin change under each polarity checks edge direction and the three-cycle latency.
- Polarity toggles on a steady pin must not produce a flag.
- A clear write placed exactly on the cycle of a detected edge checks that the edge wins.
- Pins held high through reset, with rising polarity selected at once, show whether the warm-up guard works.

A long random phase then mixes pin toggles, gating and bus writes. It separates correct ordering of write, edge and mask from designs that are only right when those events happen alone.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;

    typedef enum logic [1:0] {
        ST_FILL_A = 2'd0,
        ST_FILL_B = 2'd1,
        ST_FILL_C = 2'd2,
        ST_LIVE   = 2'd3
    } warm_state_t;

    localparam logic [1:0] ADDR_ENABLE   = 2'd0;
    localparam logic [1:0] ADDR_FLAG     = 2'd1;
    localparam logic [1:0] ADDR_POLARITY = 2'd2;

endpackage

// File: rtl/pin_edge_warmup.sv
module pin_edge_warmup
    import pin_edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic live
);

    warm_state_t state_q;
    warm_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL_A: state_d = ST_FILL_B;
            ST_FILL_B: state_d = ST_FILL_C;
            ST_FILL_C: state_d = ST_LIVE;
            ST_LIVE:   state_d = ST_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL_A;
        else        state_q <= state_d;
    end

    always_comb begin
        live = (state_q == ST_LIVE);
    end

    // once detection is open it stays open until reset
    assert_live_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> live);

endmodule

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_gate,
    input  logic [NPINS-1:0] pol_rise,
    output logic [NPINS-1:0] hit
);

    logic [NPINS-1:0] sync_a;
    logic [NPINS-1:0] sync_b;
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            prev_q <= '0;
        end else begin
            sync_a <= pin_in;
            sync_b <= sync_a;
            prev_q <= sync_b;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic went_up;
        logic went_down;
        assign went_up   =  sync_b[i] & ~prev_q[i];
        assign went_down = ~sync_b[i] &  prev_q[i];
        assign hit[i]    = live & ~pin_gate[i] & (pol_rise[i] ? went_up : went_down);
    end

endmodule

// File: rtl/pin_edge_regs.sv
module pin_edge_regs
    import pin_edge_irq_pkg::*;
#(
    parameter int NPINS   = 2,
    parameter int LSB_BIT = 5,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  hit,
    output logic [NPINS-1:0]  pol_rise,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] flag_q
);

    localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(((1 << NPINS) - 1) << LSB_BIT);

    logic [DATA_W-1:0] pol_q;
    logic [DATA_W-1:0] hit_w;
    logic [DATA_W-1:0] flag_d;
    logic [DATA_W-1:0] wmask;
    logic              wr_en;

    assign wr_en = bus_sel & bus_wr;
    assign wmask = bus_wdata & IMPL_MASK;

    always_comb begin
        hit_w = '0;
        for (int i = 0; i < NPINS; i++) hit_w[LSB_BIT+i] = hit[i];
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pol
        assign pol_rise[i] = pol_q[LSB_BIT+i];
    end

    // clear by ones first, then a same-cycle edge re-sets the bit
    always_comb begin
        flag_d = flag_q;
        if (wr_en && bus_addr == ADDR_FLAG) flag_d = flag_q & ~wmask;
        flag_d = flag_d | hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en && bus_addr == ADDR_ENABLE)   en_q  <= wmask;
            if (wr_en && bus_addr == ADDR_POLARITY) pol_q <= wmask;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                ADDR_ENABLE:   bus_rdata = en_q;
                ADDR_FLAG:     bus_rdata = flag_q;
                ADDR_POLARITY: bus_rdata = pol_q;
                default:       bus_rdata = '0;
            endcase
        end
    end

    for (genvar b = 0; b < NPINS; b++) begin : g_chk
        localparam int BIT = LSB_BIT + b;

        assert_flag_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[BIT]) |-> $past(hit[b]));

        assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && bus_addr == ADDR_FLAG && !bus_wdata[BIT] && !hit[b])
            |=> (flag_q[BIT] == $past(flag_q[BIT])));

        assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            hit[b] |=> flag_q[BIT]);
    end

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
    import pin_edge_irq_pkg::*;
#(
    parameter int NPINS   = 2,
    parameter int LSB_BIT = 5,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_gate,
    output logic              irq
);

    logic              live;
    logic [NPINS-1:0]  hit;
    logic [NPINS-1:0]  pol_rise;
    logic [DATA_W-1:0] en_w;
    logic [DATA_W-1:0] flag_w;

    pin_edge_warmup u_warm (
        .clk  (clk),
        .rst_n(rst_n),
        .live (live)
    );

    pin_edge_det #(.NPINS(NPINS)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live),
        .pin_in  (pin_in),
        .pin_gate(pin_gate),
        .pol_rise(pol_rise),
        .hit     (hit)
    );

    pin_edge_regs #(.NPINS(NPINS), .LSB_BIT(LSB_BIT), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hit      (hit),
        .pol_rise (pol_rise),
        .en_q     (en_w),
        .flag_q   (flag_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag_w & en_w);
    end

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_w & en_w)) |=> irq);

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_w & en_w)) |=> !irq);

    assert_quiet_warmup_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (hit == '0));

    for (genvar b = 0; b < NPINS; b++) begin : g_gate
        assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pin_gate[b] |=> !$rose(flag_w[LSB_BIT+b]));
    end

endmodule

// File: tb/pin_edge_irq_tb.sv
`timescale 1ns/1ps
module pin_edge_irq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_gate = 2'b00;
    logic       irq;

    always #2.5 clk = ~clk;

    pin_edge_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_gate(pin_gate), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] last_rd;
    logic       last_irq;
    logic [1:0] cur_p = 2'b00;
    logic [1:0] cur_g = 2'b00;

    // reference model built from the requirements
    logic [1:0] m_h1, m_h2, m_h3, m_en, m_fl, m_pol, m_hit, m_wb;
    logic       m_irq;
    int         m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h1 = 0; m_h2 = 0; m_h3 = 0; m_en = 0; m_fl = 0; m_pol = 0;
            m_irq = 0; m_cnt = 0;
        end else begin
            for (int i = 0; i < 2; i++)
                m_hit[i] = (m_cnt == 3) && !pin_gate[i] &&
                           (m_pol[i] ? (m_h2[i] && !m_h3[i]) : (!m_h2[i] && m_h3[i]));
            m_irq = |(m_fl & m_en);
            m_wb  = bus_wdata[6:5];
            if (bus_sel && bus_wr) begin
                if (bus_addr == 2'd0) m_en  = m_wb;
                if (bus_addr == 2'd1) m_fl  = m_fl & ~m_wb;
                if (bus_addr == 2'd2) m_pol = m_wb;
            end
            m_fl = m_fl | m_hit;
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = pin_in;
            if (m_cnt < 3) m_cnt++;
        end
    end

    function automatic logic [7:0] exp_rd(input logic s, input logic [1:0] a);
        if (!s) return 8'h00;
        case (a)
            2'd0: return {1'b0, m_en, 5'b0};
            2'd1: return {1'b0, m_fl, 5'b0};
            2'd2: return {1'b0, m_pol, 5'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        last_rd  = bus_rdata;
        last_irq = irq;
        if (rst_n) begin
            chk("R8 irq vs model", {7'b0, irq}, {7'b0, m_irq});
            chk("R2 readback vs model", bus_rdata, exp_rd(bus_sel, bus_addr));
        end
        pin_in = cur_p; pin_gate = cur_g;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        cyc(1'b1, 1'b0, a, 8'h00);
        cyc(1'b1, 1'b0, a, 8'h00);
        v = last_rd;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 2'd1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = 32'h0000_5eed;
        void'($urandom(seed));

        // R11: pins high through reset, rising polarity written at once
        cur_p = 2'b11;
        pin_in = 2'b11;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        wr(2'd2, 8'h60);
        idle(6);
        rd(2'd1, v); chk("R11 no flag from reset level", v, 8'h00);

        // R1: reset values
        @(negedge clk) rst_n = 1'b0;
        cur_p = 2'b00;
        pin_in = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(2'd0, v); chk("R1 enable reset", v, 8'h00);
        rd(2'd1, v); chk("R1 flag reset", v, 8'h00);
        rd(2'd2, v); chk("R1 polarity reset", v, 8'h00);
        idle(4);

        // R2: map and unimplemented bits
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R2 enable implemented bits", v, 8'h60);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R2 address 3 empty", v, 8'h00);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        chk("R2 no select reads zero", last_rd, 8'h00);
        wr(2'd0, 8'h00);

        // R3: falling edge on pin 0, three-edge latency
        cur_p = 2'b11; idle(6);
        wr(2'd1, 8'hFF);
        idle(2);
        cur_p = 2'b10;
        cyc(1'b1, 1'b0, 2'd1, 8'h00);
        cyc(1'b1, 1'b0, 2'd1, 8'h00); chk("R3 not after edge 1", last_rd, 8'h00);
        cyc(1'b1, 1'b0, 2'd1, 8'h00); chk("R3 not after edge 2", last_rd, 8'h00);
        cyc(1'b1, 1'b0, 2'd1, 8'h00); chk("R3 set after edge 3", last_rd, 8'h20);

        // R6: write zero keeps, write one clears
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R6 zero write keeps", v, 8'h20);
        wr(2'd1, 8'h20);
        rd(2'd1, v); chk("R6 one write clears", v, 8'h00);

        // R4: rising polarity; falling edge ignored
        wr(2'd2, 8'h60);
        cur_p = 2'b00; idle(6);
        rd(2'd1, v); chk("R4 falling ignored when rising selected", v, 8'h00);
        cur_p = 2'b10; idle(5);
        rd(2'd1, v); chk("R4 rising sets pin 1", v, 8'h40);

        // R5: polarity toggles on steady pins
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h00); idle(4);
        wr(2'd2, 8'h60); idle(4);
        wr(2'd2, 8'h00); idle(4);
        rd(2'd1, v); chk("R5 polarity change alone", v, 8'h00);

        // R7: flag latched while disabled, irq masked, then unmasked
        cur_p = 2'b00; idle(6);
        rd(2'd1, v); chk("R7 flag set while disabled", v, 8'h40);
        chk("R7 irq masked", {7'b0, last_irq}, 8'h00);
        wr(2'd0, 8'h40);
        cyc(1'b1, 1'b0, 2'd1, 8'h00);
        chk("R8 irq not yet", {7'b0, last_irq}, 8'h00);
        cyc(1'b1, 1'b0, 2'd1, 8'h00);
        chk("R8 irq one cycle later", {7'b0, last_irq}, 8'h01);

        // R9: edge and clear hit same cycle (pin 1, falling polarity)
        cur_p = 2'b10; idle(6);
        wr(2'd1, 8'hFF); idle(2);
        cur_p = 2'b00;
        cyc(1'b1, 1'b0, 2'd1, 8'h00);
        cyc(1'b1, 1'b0, 2'd1, 8'h00);
        wr(2'd1, 8'h40);
        cyc(1'b1, 1'b0, 2'd1, 8'h00);
        chk("R9 edge wins over clear", last_rd, 8'h40);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h00);

        // R10: gated pin 0 ignores edges
        cur_g = 2'b01;
        cur_p = 2'b01; idle(5);
        cur_p = 2'b00; idle(5);
        cur_p = 2'b01; idle(5);
        cur_p = 2'b00; idle(5);
        rd(2'd1, v); chk("R10 gated pin no flag", v, 8'h00);
        cur_g = 2'b00; idle(5);
        rd(2'd1, v); chk("R10 ungating makes no flag", v, 8'h00);

        // random phase: checks vs model every cycle (R2, R8)
        for (int n = 0; n < 4000; n++) begin
            logic s, w;
            logic [1:0] a;
            if (($urandom % 4) == 0) cur_p = cur_p ^ 2'($urandom);
            if (($urandom % 8) == 0) cur_g = 2'($urandom);
            s = ($urandom % 8) != 0;
            w = s && (($urandom % 4) == 0);
            a = 2'($urandom);
            cyc(s, w, a, 8'($urandom));
        end
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule